// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block keeps track of the loads that an out-of-order core has in flight. Each new load takes a free queue slot and carries its sequence number. Later the load's effective address is written into that slot once the load has executed. Loads leave the queue in two ways. A commit retires every load at or below a given sequence number. A squash drops every load above a given sequence number. Either way, the slot becomes free for reuse.

When a store executes, the core presents the store's sequence number and address. The queue looks at the loads that are not older than the store and have a known address. A load conflicts when its address falls in the same coarse block as the store's address. The oldest conflicting load is recorded as the ordering violator. The store is told one cycle later that it faulted, and a wrapping violation counter advances. Only one violator is held at a time. A read strobe hands it to the core and empties the holder.

The block also keeps a flag for a blocked load. A squash that reaches further back than that load clears the flag. It also reports a combined free-capacity figure for the dispatch stage.

Top module: `ldq_order_guard`

## Requirements
- R1: Out of reset the queue is empty: load_count is 0, alloc_ready is 1, alloc_idx is 0, viol_valid, chk_fault and blk_active are 0, and viol_count is 0.
- R2: Allocation (alloc_valid with alloc_ready high) takes the lowest-numbered free slot, which alloc_idx shows before the request, and raises load_count by one on the next clock. alloc_ready is low when all DEPTH slots are used. A request made while the queue is full changes nothing.
- R3: A commit retires, on the next clock, every held load whose sequence number is less than or equal to commit_seq, and frees its slot. A commit and a squash in the same cycle both apply to the queue contents held at the start of that cycle.
- R4: A squash removes, on the next clock, every held load whose sequence number is greater than squash_seq, and frees its slot.
- R5: A store check compares only loads whose sequence number is greater than or equal to chk_seq and whose address has been written. Two addresses match when they agree in all bits above the low BLK_BITS bits (bits 7:0 by default are ignored).
- R6: When one or more loads match and no violator is pending, the matching load with the smallest sequence number is recorded. viol_valid, viol_idx and viol_seq show it, chk_fault is high for exactly the one cycle after the check, and viol_count rises by one.
- R7: While a violator is pending at the start of a cycle, a store check performs no search. chk_fault stays low, viol_count is unchanged, and the held violator stays the same.
- R8: viol_rd while a violator is pending clears viol_valid on the next clock. viol_rd with nothing pending has no effect.
- R9: blk_set records a blocked load with sequence number blk_seq and raises blk_active on the next clock. A squash with squash_seq strictly less than the recorded number clears it. A squash with squash_seq greater than or equal to that number leaves it set. When blk_set and a clearing squash come together, the flag ends up set.
- R10: free_cap equals min(DEPTH - load_count, stq_free) - 1, saturating at 0. It follows stq_free combinationally.
- R11: An address write (ex_valid, ex_idx, ex_addr) takes effect only if slot ex_idx holds a load at the start of the cycle. A newly allocated load starts with no address, so it cannot match until its address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate a load |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Slot the next allocation will take |
| ex_valid | input | 1 | Executed-address write strobe |
| ex_idx | input | IDX_W | Slot whose address is written |
| ex_addr | input | ADDR_W | Effective address of the load |
| chk_valid | input | 1 | Store check request |
| chk_seq | input | SEQ_W | Sequence number of the store |
| chk_addr | input | ADDR_W | Address of the store |
| chk_fault | output | 1 | One-cycle pulse: the previous check found a violator |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads above this number are removed |
| viol_rd | input | 1 | Read and clear the pending violator |
| viol_valid | output | 1 | A violator is pending |
| viol_idx | output | IDX_W | Slot of the pending violator |
| viol_seq | output | SEQ_W | Sequence number of the pending violator |
| viol_count | output | VCNT_W | Wrapping count of recorded violations |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blk_active | output | 1 | Blocked-load condition held |
| stq_free | input | SQF_W | Free entries reported by the store queue |
| free_cap | output | CNT_W | Combined free capacity |
| load_count | output | CNT_W | Number of loads held |

## Verification
The bench uses the default parameters: DEPTH 8, SQ_DEPTH 8, SEQ_W 16, ADDR_W 32 and BLK_BITS 8. With a depth of eight, the queue can be filled and then overfilled within a few cycles. Slot recycling can be seen after partial commits, because a freed low index is taken again before higher ones. The 256-byte block lets addresses that differ only in their low byte count as conflicts, while a neighbouring block does not. With an eight-entry store-queue figure, either input can be the smaller term of free_cap, and both the saturating zero and a full queue come up in the run.

// File: rtl/lq_pkg.sv
package lq_pkg;
  localparam int unsigned LQ_DEPTH_DEF    = 8;
  localparam int unsigned LQ_SQ_DEPTH_DEF = 8;
  localparam int unsigned LQ_SEQ_W_DEF    = 16;
  localparam int unsigned LQ_ADDR_W_DEF   = 32;
  localparam int unsigned LQ_BLK_BITS_DEF = 8;
  localparam int unsigned LQ_VCNT_W_DEF   = 16;

  // Holder state for the single recorded ordering violator
  typedef enum logic {
    VH_EMPTY   = 1'b0,
    VH_PENDING = 1'b1
  } viol_hold_e;
endpackage

// File: rtl/lq_alloc_pick.sv
module lq_alloc_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] busy,
  output logic [IDX_W-1:0] pick,
  output logic             full
);
  // Lowest-numbered free slot wins; scanning downward leaves it last written
  always_comb begin
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) pick = IDX_W'(i);
    end
    full = &busy;
  end
endmodule

// File: rtl/lq_entries.sv
module lq_entries #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_fire,
  input  logic [IDX_W-1:0]             alloc_slot,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         ex_valid,
  input  logic [IDX_W-1:0]             ex_idx,
  input  logic [ADDR_W-1:0]            ex_addr,
  input  logic                         commit_valid,
  input  logic [SEQ_W-1:0]             commit_seq,
  input  logic                         squash_valid,
  input  logic [SEQ_W-1:0]             squash_seq,
  output logic [DEPTH-1:0]             valid_q,
  output logic [DEPTH-1:0]             aval_q,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seq_q,
  output logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  output logic [DEPTH-1:0]             kill
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              v_r;
    logic              av_r;
    logic [SEQ_W-1:0]  s_r;
    logic [ADDR_W-1:0] a_r;
    logic              take;
    logic              wr_addr;

    assign take    = alloc_fire && (alloc_slot == IDX_W'(g));
    assign wr_addr = ex_valid && (ex_idx == IDX_W'(g)) && v_r;
    assign kill[g] = v_r && ((commit_valid && (s_r <= commit_seq)) ||
                             (squash_valid && (s_r > squash_seq)));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_r  <= 1'b0;
        av_r <= 1'b0;
      end else if (take) begin
        v_r  <= 1'b1;
        av_r <= 1'b0;
      end else begin
        if (kill[g]) v_r <= 1'b0;
        if (wr_addr) av_r <= 1'b1;
      end
    end

    // Payload storage carries no reset
    always_ff @(posedge clk) begin
      if (take) s_r <= alloc_seq;
      if (wr_addr) a_r <= ex_addr;
    end

    assign valid_q[g] = v_r;
    assign aval_q[g]  = av_r;
    assign seq_q[g]   = s_r;
    assign addr_q[g]  = a_r;

    // R3
    slot_kill_chk: assert property (@(posedge clk) disable iff (rst)
      kill[g] |=> !v_r);
  end
endmodule

// File: rtl/lq_viol_unit.sv
module lq_viol_unit
  import lq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int IDX_W    = 3,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int BLK_BITS = 8,
  parameter int VCNT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DEPTH-1:0]             valid_q,
  input  logic [DEPTH-1:0]             aval_q,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_q,
  input  logic                         chk_valid,
  input  logic [SEQ_W-1:0]             chk_seq,
  input  logic [ADDR_W-1:0]            chk_addr,
  input  logic                         viol_rd,
  output logic                         chk_fault,
  output logic                         viol_valid,
  output logic [IDX_W-1:0]             viol_idx,
  output logic [SEQ_W-1:0]             viol_seq,
  output logic [VCNT_W-1:0]            viol_count
);
  localparam int TAG_W = ADDR_W - BLK_BITS;

  viol_hold_e        hold_q;
  logic [DEPTH-1:0]  hit;
  logic              found;
  logic [IDX_W-1:0]  best_idx;
  logic [SEQ_W-1:0]  best_seq;
  logic              record;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = valid_q[g] && aval_q[g] && (seq_q[g] >= chk_seq) &&
                    (addr_q[g][ADDR_W-1:BLK_BITS] == chk_addr[ADDR_W-1:BLK_BITS]);
  end

  // Oldest matching load: smallest sequence number among hits
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_seq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i] && (!found || (seq_q[i] < best_seq))) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_seq = seq_q[i];
      end
    end
  end

  assign record = chk_valid && (hold_q == VH_EMPTY) && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= VH_EMPTY;
      chk_fault  <= 1'b0;
      viol_count <= '0;
      viol_idx   <= '0;
      viol_seq   <= '0;
    end else begin
      chk_fault <= record;
      if (hold_q == VH_PENDING) begin
        if (viol_rd) hold_q <= VH_EMPTY;
      end else if (record) begin
        hold_q     <= VH_PENDING;
        viol_idx   <= best_idx;
        viol_seq   <= best_seq;
        viol_count <= viol_count + VCNT_W'(1);
      end
    end
  end

  assign viol_valid = (hold_q == VH_PENDING);

  // R6
  fault_has_viol_chk: assert property (@(posedge clk) disable iff (rst)
    chk_fault |-> viol_valid);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    chk_fault |-> (viol_count == $past(viol_count) + VCNT_W'(1)));
  // R7
  viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && !viol_rd) |=> (viol_valid && $stable(viol_seq) && $stable(viol_idx) && !chk_fault));
  // R8
  viol_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_valid && viol_rd) |=> !viol_valid);
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard
  import lq_pkg::*;
#(
  parameter int DEPTH    = LQ_DEPTH_DEF,
  parameter int SQ_DEPTH = LQ_SQ_DEPTH_DEF,
  parameter int SEQ_W    = LQ_SEQ_W_DEF,
  parameter int ADDR_W   = LQ_ADDR_W_DEF,
  parameter int BLK_BITS = LQ_BLK_BITS_DEF,
  parameter int VCNT_W   = LQ_VCNT_W_DEF,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SQF_W   = $clog2(SQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              ex_valid,
  input  logic [IDX_W-1:0]  ex_idx,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              chk_valid,
  input  logic [SEQ_W-1:0]  chk_seq,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_fault,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              viol_rd,
  output logic              viol_valid,
  output logic [IDX_W-1:0]  viol_idx,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [VCNT_W-1:0] viol_count,
  input  logic              blk_set,
  input  logic [SEQ_W-1:0]  blk_seq,
  output logic              blk_active,
  input  logic [SQF_W-1:0]  stq_free,
  output logic [CNT_W-1:0]  free_cap,
  output logic [CNT_W-1:0]  load_count
);
  logic [DEPTH-1:0]             valid_v;
  logic [DEPTH-1:0]             aval_v;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_v;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_v;
  logic [DEPTH-1:0]             kill_v;
  logic                         full;
  logic                         alloc_fire;
  logic [CNT_W-1:0]             count_q;
  logic [CNT_W-1:0]             n_kill;
  logic [SEQ_W-1:0]             blk_seq_q;

  lq_alloc_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .busy (valid_v),
    .pick (alloc_idx),
    .full (full)
  );

  assign alloc_ready = !full;
  assign alloc_fire  = alloc_valid && !full;

  lq_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_ent (
    .clk          (clk),
    .rst          (rst),
    .alloc_fire   (alloc_fire),
    .alloc_slot   (alloc_idx),
    .alloc_seq    (alloc_seq),
    .ex_valid     (ex_valid),
    .ex_idx       (ex_idx),
    .ex_addr      (ex_addr),
    .commit_valid (commit_valid),
    .commit_seq   (commit_seq),
    .squash_valid (squash_valid),
    .squash_seq   (squash_seq),
    .valid_q      (valid_v),
    .aval_q       (aval_v),
    .seq_q        (seq_v),
    .addr_q       (addr_v),
    .kill         (kill_v)
  );

  lq_viol_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                 .BLK_BITS(BLK_BITS), .VCNT_W(VCNT_W)) u_viol (
    .clk        (clk),
    .rst        (rst),
    .valid_q    (valid_v),
    .aval_q     (aval_v),
    .seq_q      (seq_v),
    .addr_q     (addr_v),
    .chk_valid  (chk_valid),
    .chk_seq    (chk_seq),
    .chk_addr   (chk_addr),
    .viol_rd    (viol_rd),
    .chk_fault  (chk_fault),
    .viol_valid (viol_valid),
    .viol_idx   (viol_idx),
    .viol_seq   (viol_seq),
    .viol_count (viol_count)
  );

  always_comb begin
    n_kill = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (kill_v[i]) n_kill = n_kill + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + CNT_W'(alloc_fire) - n_kill;
  end

  assign load_count = count_q;

  // Blocked-load flag: clearing squash applies first, a new set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_active <= 1'b0;
      blk_seq_q  <= '0;
    end else begin
      if (squash_valid && blk_active && (squash_seq < blk_seq_q)) blk_active <= 1'b0;
      if (blk_set) begin
        blk_active <= 1'b1;
        blk_seq_q  <= blk_seq;
      end
    end
  end

  always_comb begin
    int lq_left;
    int sq_left;
    int low;
    lq_left  = DEPTH - int'(count_q);
    sq_left  = int'(stq_free);
    low      = (sq_left < lq_left) ? sq_left : lq_left;
    free_cap = (low > 0) ? CNT_W'(low - 1) : '0;
  end

  // R2
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_v) == int'(count_q));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(count_q) <= DEPTH);
  // R9
  blk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (squash_valid && blk_active && (squash_seq < blk_seq_q) && !blk_set) |=> !blk_active);
  // R10
  cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(free_cap) <= int'(stq_free)) && (int'(free_cap) + int'(count_q) <= DEPTH));
endmodule

// File: tb/tb_ldq_order_guard.sv
`timescale 1ns/100ps
module tb_ldq_order_guard;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_valid;
  logic [15:0] alloc_seq;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        ex_valid;
  logic [2:0]  ex_idx;
  logic [31:0] ex_addr;
  logic        chk_valid;
  logic [15:0] chk_seq;
  logic [31:0] chk_addr;
  logic        chk_fault;
  logic        commit_valid;
  logic [15:0] commit_seq;
  logic        squash_valid;
  logic [15:0] squash_seq;
  logic        viol_rd;
  logic        viol_valid;
  logic [2:0]  viol_idx;
  logic [15:0] viol_seq;
  logic [15:0] viol_count;
  logic        blk_set;
  logic [15:0] blk_seq;
  logic        blk_active;
  logic [3:0]  stq_free;
  logic [3:0]  free_cap;
  logic [3:0]  load_count;

  ldq_order_guard dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .ex_valid(ex_valid), .ex_idx(ex_idx), .ex_addr(ex_addr),
    .chk_valid(chk_valid), .chk_seq(chk_seq), .chk_addr(chk_addr), .chk_fault(chk_fault),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .viol_rd(viol_rd), .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_seq(viol_seq),
    .viol_count(viol_count),
    .blk_set(blk_set), .blk_seq(blk_seq), .blk_active(blk_active),
    .stq_free(stq_free), .free_cap(free_cap), .load_count(load_count)
  );

  always #2.5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string tag   = "R1";

  // Behavioural reference state
  bit          m_v   [D];
  bit          m_av  [D];
  int          m_seq [D];
  logic [31:0] m_addr[D];
  int          m_count;
  bit          m_fault;
  bit          m_vv;
  int          m_vidx;
  int          m_vseq;
  int          m_vcnt;
  bit          m_blk;
  int          m_bseq;

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < D; i++) if (!m_v[i]) return i;
    return 0;
  endfunction

  task automatic compare_all();
    int lq_left;
    int low;
    chk("load_count", int'(load_count), m_count);
    chk("alloc_ready", int'(alloc_ready), (m_count < D) ? 1 : 0);
    if (m_count < D) chk("alloc_idx", int'(alloc_idx), lowest_free());
    lq_left = D - m_count;
    low = (int'(stq_free) < lq_left) ? int'(stq_free) : lq_left;
    chk("free_cap", int'(free_cap), (low > 0) ? low - 1 : 0);
    chk("chk_fault", int'(chk_fault), int'(m_fault));
    chk("viol_valid", int'(viol_valid), int'(m_vv));
    if (m_vv) begin
      chk("viol_idx", int'(viol_idx), m_vidx);
      chk("viol_seq", int'(viol_seq), m_vseq);
    end
    chk("viol_count", int'(viol_count), m_vcnt);
    chk("blk_active", int'(blk_active), int'(m_blk));
  endtask

  task automatic model_step();
    bit kill[D];
    bit fire;
    int pick;
    bit hit_any;
    int h_idx;
    int h_seq;
    fire = alloc_valid && (m_count < D);
    pick = lowest_free();
    hit_any = 0; h_idx = 0; h_seq = 0;
    for (int i = 0; i < D; i++) begin
      kill[i] = m_v[i] && ((commit_valid && m_seq[i] <= int'(commit_seq)) ||
                           (squash_valid && m_seq[i] > int'(squash_seq)));
      if (chk_valid && m_v[i] && m_av[i] && m_seq[i] >= int'(chk_seq) &&
          (m_addr[i] >> 8) == (chk_addr >> 8)) begin
        if (!hit_any || m_seq[i] < h_seq) begin
          hit_any = 1; h_idx = i; h_seq = m_seq[i];
        end
      end
    end
    // violator holder
    m_fault = 0;
    if (m_vv) begin
      if (viol_rd) m_vv = 0;
    end else if (hit_any) begin
      m_vv = 1; m_vidx = h_idx; m_vseq = h_seq; m_vcnt = (m_vcnt + 1) % 65536;
      m_fault = 1;
    end
    // blocked flag
    if (squash_valid && m_blk && int'(squash_seq) < m_bseq) m_blk = 0;
    if (blk_set) begin m_blk = 1; m_bseq = int'(blk_seq); end
    // entries
    for (int i = 0; i < D; i++) begin
      if (ex_valid && int'(ex_idx) == i && m_v[i]) begin
        m_av[i] = 1; m_addr[i] = ex_addr;
      end
      if (kill[i]) begin m_v[i] = 0; m_count--; end
    end
    if (fire) begin
      m_v[pick] = 1; m_av[pick] = 0; m_seq[pick] = int'(alloc_seq); m_count++;
    end
  endtask

  task automatic clear_in();
    alloc_valid = 0; alloc_seq = '0; ex_valid = 0; ex_idx = '0; ex_addr = '0;
    chk_valid = 0; chk_seq = '0; chk_addr = '0; commit_valid = 0; commit_seq = '0;
    squash_valid = 0; squash_seq = '0; viol_rd = 0; blk_set = 0; blk_seq = '0;
  endtask

  task automatic cycle();
    #0.5;
    compare_all();
    model_step();
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  task automatic nop(); cycle(); endtask
  task automatic do_alloc(int s); alloc_valid = 1; alloc_seq = 16'(s); cycle(); endtask
  task automatic do_exec(int i, logic [31:0] a); ex_valid = 1; ex_idx = 3'(i); ex_addr = a; cycle(); endtask
  task automatic do_chk(int s, logic [31:0] a); chk_valid = 1; chk_seq = 16'(s); chk_addr = a; cycle(); endtask
  task automatic do_commit(int s); commit_valid = 1; commit_seq = 16'(s); cycle(); endtask
  task automatic do_squash(int s); squash_valid = 1; squash_seq = 16'(s); cycle(); endtask
  task automatic do_rd(); viol_rd = 1; cycle(); endtask
  task automatic do_blk(int s); blk_set = 1; blk_seq = 16'(s); cycle(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    clear_in();
    stq_free = 4'd8;
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_av[i] = 0; m_seq[i] = 0; m_addr[i] = '0;
    end
    m_count = 0; m_fault = 0; m_vv = 0; m_vidx = 0; m_vseq = 0; m_vcnt = 0;
    m_blk = 0; m_bseq = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    tag = "R1"; nop(); nop();

    // R2: fill, then request while full
    tag = "R2";
    for (int k = 1; k <= 8; k++) do_alloc(k * 10);
    do_alloc(90);
    nop();

    // R11: address writes; slot 5 (seq 60) left without address
    tag = "R11";
    do_exec(0, 32'h1000_0010);
    do_exec(1, 32'h2000_0000);
    do_exec(2, 32'h1000_0080);
    do_exec(3, 32'h1000_0100);
    do_exec(4, 32'h1000_00FF);
    do_exec(6, 32'h1000_0001);
    do_exec(7, 32'h3000_0000);

    // R5/R6: store 35 in block 0x100000xx -> oldest younger hit is seq 50
    tag = "R6"; do_chk(35, 32'h1000_0000); nop();
    // R7: pending violator blocks search
    tag = "R7"; do_chk(5, 32'h3000_0000); nop();
    // R8: read clears, second read no effect
    tag = "R8"; do_rd(); do_rd(); nop();
    // R5: no younger match, then equal sequence number matches
    tag = "R5";
    do_chk(75, 32'h1000_0000);
    do_chk(80, 32'h3000_0040);
    do_rd();
    do_chk(35, 32'h1000_0100);
    do_rd();
    // R7: read and check in the same cycle while pending
    tag = "R7";
    do_chk(35, 32'h1000_0000);
    viol_rd = 1; chk_valid = 1; chk_seq = 16'd65; chk_addr = 32'h1000_0000; cycle();
    do_chk(65, 32'h1000_0000);
    do_rd();

    // R3: commit oldest three, recycle low slots
    tag = "R3";
    do_commit(30);
    do_alloc(100);
    do_alloc(110);
    // R11: write to freed slot 2 is ignored, then fresh allocation has no address
    tag = "R11";
    do_exec(2, 32'h1000_0000);
    do_chk(85, 32'h1000_0000);
    do_alloc(120);
    do_chk(115, 32'h1000_0000);
    do_exec(2, 32'h1000_0040);
    do_chk(115, 32'h1000_0000);
    do_rd();

    // R10: full queue and store queue limits
    tag = "R10";
    stq_free = 4'd0; nop();
    stq_free = 4'd3; nop();
    stq_free = 4'd8;

    // R4: squash above 60
    tag = "R4"; do_squash(60); nop();

    // R9: blocked flag
    tag = "R9";
    do_blk(55);
    do_squash(58);
    do_squash(55);
    do_squash(50);
    do_blk(52);
    blk_set = 1; blk_seq = 16'd45; squash_valid = 1; squash_seq = 16'd40; cycle();
    nop();

    // R10: varying store-queue figure with few loads
    tag = "R10";
    stq_free = 4'd8; nop();
    stq_free = 4'd5; nop();
    stq_free = 4'd1; nop();
    stq_free = 4'd0; nop();
    stq_free = 4'd8;

    // R3: commit and squash together
    tag = "R3";
    do_alloc(200);
    commit_valid = 1; commit_seq = 16'd45; squash_valid = 1; squash_seq = 16'd100; cycle();
    nop();
    do_commit(300);
    tag = "R2";
    for (int k = 0; k < 9; k++) do_alloc(400 + k);
    do_commit(402);
    do_alloc(500);
    nop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule